// File: doc/BRIEF.md
# Register Wipe and Generator Reseed Sequencer

This block runs the self-clearing housekeeping triggers of a block-cipher unit. A six-bit trigger register holds one request bit per task: a cipher start, four bank wipes (key, IV, input data, output data) and a reseed of the internal pseudo-random generator. Each wipe streams pseudo-random words, one per accepted transfer, to the register bank that owns the data. The word index runs from zero up to the bank's depth. The key wipe is meant for all three key stores at once: the initial key, the expanded full key and the decryption key. The reseed fetches a 32-bit seed over a request/acknowledge entropy port.

The trigger bits for the four wipes and the reseed come out of reset set. A full random wipe and reseed therefore run with no software action, and every bit clears itself when its task completes. While any wipe or reseed is pending or running, the shared idle flag stays low. The wipe stream is valid/ready. The sequencer raises `wr_valid` and holds the bank, index and data steady until `wr_ready` is seen high at a clock edge. Only then does it advance the index and the generator. A bank that keeps `wr_ready` low stalls the sequence for as long as it likes, and nothing is lost.

Top module: `cipher_wipe_seq`

## Requirements
- R1: Trigger bit positions are 0 start, 1 key wipe, 2 IV wipe, 3 input wipe, 4 output wipe and 5 reseed. Reset sets `trig_q` to 6'b111110.
- R2: A trigger write ORs its 1 bits into `trig_q`, and 0 bits have no effect. A bit drops in the cycle after its task finishes. If a write sets that same bit in the finishing cycle, the bit stays set and the task runs again.
- R3: Only one task runs at a time, and each task is picked in an idle-phase cycle. The reseed goes first, then the wipes in ascending bit order. Start goes only when bits 5..1 are all clear.
- R4: During a reseed `ent_req` stays high until `ent_ack` arrives with nonzero `ent_data`. That seed becomes the generator state. An acknowledge carrying zero is ignored and the request stays up.
- R5: A wipe drives `wr_valid` with bank code 0 key, 1 IV, 2 input, 3 output. The index `wr_idx` goes from 0 to the bank depth minus one (KEY_WORDS, IV_WORDS or DATA_WORDS). Bank, index and data hold while `wr_ready` is low and advance only on a handshake.
- R6: `wr_data` is the generator state, and the state is never zero. Each accepted word steps it once: shift right by one, then XOR 32'h80200003 if the bit shifted out was 1.
- R7: `idle` is high exactly when trigger bits 5..1 are all zero.
- R8: Start produces a one-cycle `start_pulse` in the cycle after it is picked, and bit 0 clears at the same time.
- R9: After reset, with no writes, the sequencer runs the reseed and then the key, IV, input and output wipes, and it ends idle with `trig_q` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_we | input | 1 | Trigger register write strobe |
| trig_wdata | input | 6 | Trigger write data, 1 bits set requests |
| trig_q | output | 6 | Pending trigger bits |
| idle | output | 1 | No wipe or reseed pending |
| start_pulse | output | 1 | One-cycle cipher start |
| ent_req | output | 1 | Entropy request |
| ent_ack | input | 1 | Entropy acknowledge |
| ent_data | input | WORD_W | Seed delivered with the acknowledge |
| wr_valid | output | 1 | Wipe word valid |
| wr_ready | input | 1 | Bank accepts the wipe word |
| wr_bank | output | 2 | Target bank code |
| wr_idx | output | IDX_W | Word index inside the bank |
| wr_data | output | WORD_W | Pseudo-random wipe word |

## Verification
The bench builds the block with KEY_WORDS=8, IV_WORDS=2 and DATA_WORDS=3, so each bank has a different depth. This makes the last-word detection depend on which bank is selected, and an off-by-one in any one depth shows up in the observed index sequence. With short banks the full six-task sequence fits in a few dozen cycles. That leaves room to cover a zero seed being rejected, a wipe stalled by back-pressure, and a re-write landing on the completion cycle of the key wipe.

// File: rtl/cws_pkg.sv
package cws_pkg;
  localparam int TRIG_W = 6;
  localparam int TB_START  = 0;
  localparam int TB_RESEED = 5;
  localparam logic [TRIG_W-1:0] TRIG_RST = 6'b111110;

  typedef enum logic [1:0] {
    BANK_KEY  = 2'd0,
    BANK_IV   = 2'd1,
    BANK_DIN  = 2'd2,
    BANK_DOUT = 2'd3
  } bank_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SEED = 2'd1,
    PH_FILL = 2'd2
  } phase_e;
endpackage

// File: rtl/cws_lfsr.sv
module cws_lfsr #(
  parameter int W = 32,
  parameter logic [W-1:0] MASK = 32'h80200003,
  parameter logic [W-1:0] RST  = 32'h6A09E667
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] state
);
  logic [W-1:0] nxt;

  always_comb begin
    nxt = state >> 1;
    if (state[0]) nxt = nxt ^ MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= RST;
    else if (load) state <= load_val;
    else if (step) state <= nxt;
  end

  // R6: the generator never holds zero
  p_state_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);
  // R3: a reseed and a wipe word never touch the generator together
  p_load_step_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && step));
endmodule

// File: rtl/cws_pick.sv
module cws_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
    any = |req;
  end
endmodule

// File: rtl/cws_wordctr.sv
module cws_wordctr
  import cws_pkg::*;
#(
  parameter int KEY_WORDS  = 8,
  parameter int IV_WORDS   = 4,
  parameter int DATA_WORDS = 4,
  parameter int IDX_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic             active,
  input  bank_e            bank,
  output logic [IDX_W-1:0] idx,
  output logic             last
);
  logic [IDX_W:0] len_tab [4];

  for (genvar g = 0; g < 4; g++) begin : g_len
    localparam int L = (g == 0) ? KEY_WORDS : (g == 1) ? IV_WORDS : DATA_WORDS;
    assign len_tab[g] = (IDX_W + 1)'(L);
  end

  assign last = ({1'b0, idx} == (len_tab[bank] - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx <= '0;
    else if (clr) idx <= '0;
    else if (adv) idx <= idx + 1'b1;
  end

  // R5: the index stays inside the selected bank
  p_idx_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> ({1'b0, idx} < len_tab[bank]));
endmodule

// File: rtl/cipher_wipe_seq.sv
module cipher_wipe_seq
  import cws_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int KEY_WORDS  = 8,
  parameter int IV_WORDS   = 4,
  parameter int DATA_WORDS = 4,
  parameter logic [WORD_W-1:0] LFSR_MASK = 32'h80200003,
  parameter logic [WORD_W-1:0] LFSR_RST  = 32'h6A09E667,
  localparam int MAX_A     = (KEY_WORDS > IV_WORDS) ? KEY_WORDS : IV_WORDS,
  localparam int MAX_WORDS = (MAX_A > DATA_WORDS) ? MAX_A : DATA_WORDS,
  localparam int IDX_W     = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_we,
  input  logic [5:0]        trig_wdata,
  output logic [5:0]        trig_q,
  output logic              idle,
  output logic              start_pulse,
  output logic              ent_req,
  input  logic              ent_ack,
  input  logic [WORD_W-1:0] ent_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [1:0]        wr_bank,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [WORD_W-1:0] wr_data
);
  phase_e phase_q, phase_d;
  bank_e  bank_q, bank_d;
  logic [TRIG_W-1:0] trig_r, trig_d, done, bank_bit;
  logic start_d, ctr_clr, ctr_adv, last;
  logic lfsr_load, lfsr_step, wipe_any, seed_ok;
  logic [1:0] pick_idx;

  cws_pick #(.N(4), .IW(2)) u_pick (
    .req (trig_r[4:1]),
    .any (wipe_any),
    .idx (pick_idx)
  );

  cws_wordctr #(
    .KEY_WORDS (KEY_WORDS),
    .IV_WORDS  (IV_WORDS),
    .DATA_WORDS(DATA_WORDS),
    .IDX_W     (IDX_W)
  ) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ctr_clr),
    .adv   (ctr_adv),
    .active(wr_valid),
    .bank  (bank_q),
    .idx   (wr_idx),
    .last  (last)
  );

  cws_lfsr #(.W(WORD_W), .MASK(LFSR_MASK), .RST(LFSR_RST)) u_lfsr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (lfsr_load),
    .load_val(ent_data),
    .step    (lfsr_step),
    .state   (wr_data)
  );

  assign seed_ok  = ent_ack && (ent_data != '0);
  assign bank_bit = TRIG_W'(2) << bank_q;

  always_comb begin
    phase_d   = phase_q;
    bank_d    = bank_q;
    done      = '0;
    start_d   = 1'b0;
    ctr_clr   = 1'b0;
    ctr_adv   = 1'b0;
    lfsr_load = 1'b0;
    lfsr_step = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (trig_r[TB_RESEED]) begin
          phase_d = PH_SEED;
        end else if (wipe_any) begin
          phase_d = PH_FILL;
          bank_d  = bank_e'(pick_idx);
          ctr_clr = 1'b1;
        end else if (trig_r[TB_START]) begin
          start_d        = 1'b1;
          done[TB_START] = 1'b1;
        end
      end
      PH_SEED: begin
        if (seed_ok) begin
          lfsr_load       = 1'b1;
          done[TB_RESEED] = 1'b1;
          phase_d         = PH_IDLE;
        end
      end
      PH_FILL: begin
        if (wr_ready) begin
          lfsr_step = 1'b1;
          if (last) begin
            done    = bank_bit;
            phase_d = PH_IDLE;
          end else begin
            ctr_adv = 1'b1;
          end
        end
      end
      default: phase_d = PH_IDLE;
    endcase
    trig_d = (trig_r & ~done) | ({TRIG_W{trig_we}} & trig_wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      bank_q      <= BANK_KEY;
      trig_r      <= TRIG_RST;
      start_pulse <= 1'b0;
    end else begin
      phase_q     <= phase_d;
      bank_q      <= bank_d;
      trig_r      <= trig_d;
      start_pulse <= start_d;
    end
  end

  assign trig_q   = trig_r;
  assign idle     = ~|trig_r[5:1];
  assign ent_req  = (phase_q == PH_SEED);
  assign wr_valid = (phase_q == PH_FILL);
  assign wr_bank  = bank_q;

  // R4: request held until a usable seed arrives
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_req && !(ent_ack && ent_data != '0)) |=> ent_req);
  // R4: a zero seed leaves the generator untouched
  p_zero_seed_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_req && ent_ack && ent_data == '0) |=> $stable(wr_data));
  // R5: stalled word is held steady
  p_word_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_idx) && $stable(wr_bank)));
  // R3: never a reseed and a wipe at once
  p_one_task_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && ent_req));
  // R7: busy tasks keep idle low
  p_busy_not_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid || ent_req) |-> !idle);
  // R8: start never overlaps a wipe or reseed
  p_start_alone_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> (!wr_valid && !ent_req && idle));
  // R2: a finished wipe drops its bit unless rewritten
  p_drop_on_finish_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && last && !trig_we) |=> ((trig_q & $past(bank_bit)) == '0));
endmodule

// File: tb/cipher_wipe_seq_tb_top.sv
module cipher_wipe_seq_tb_top;
  localparam int KW = 8;
  localparam int IW = 2;
  localparam int DW = 3;
  localparam int MAXW = 8;
  localparam int XW = (MAXW > 1) ? $clog2(MAXW) : 1;
  localparam int LIMIT = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_we = 1'b0;
  logic [5:0] trig_wdata = '0;
  logic ent_ack = 1'b0;
  logic [31:0] ent_data = '0;
  logic wr_ready = 1'b0;
  logic [5:0] trig_q;
  logic idle, start_pulse, ent_req, wr_valid;
  logic [1:0] wr_bank;
  logic [XW-1:0] wr_idx;
  logic [31:0] wr_data;

  always #5 clk = ~clk;

  cipher_wipe_seq #(.KEY_WORDS(KW), .IV_WORDS(IW), .DATA_WORDS(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .trig_we(trig_we), .trig_wdata(trig_wdata),
    .trig_q(trig_q), .idle(idle), .start_pulse(start_pulse),
    .ent_req(ent_req), .ent_ack(ent_ack), .ent_data(ent_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_bank(wr_bank),
    .wr_idx(wr_idx), .wr_data(wr_data)
  );

  int total = 0, bad = 0, cyc = 0;
  int m_st = 0, m_bank = 0, m_idx = 0;
  logic [5:0] m_trig = 6'b111110;
  logic [31:0] m_gen = 32'h6A09E667;
  logic m_start = 1'b0;
  int tlog[$];
  int wcount[4];
  int ready_mode = 0, ent_cnt = 2, zero_next = 0;
  logic [31:0] seed_src = 32'h1234_5679;

  function automatic logic [31:0] gen_step(logic [31:0] s);
    logic [31:0] n;
    n = s >> 1;
    if (s[0]) n = n ^ 32'h80200003;
    return n;
  endfunction

  function automatic int blen(int b);
    return (b == 0) ? KW : (b == 1) ? IW : DW;
  endfunction

  // behavioural reference, advanced on every edge
  always @(posedge clk) begin
    logic [5:0] dn;
    int lo;
    dn = '0;
    if (!rst_n) begin
      m_st = 0; m_bank = 0; m_idx = 0; m_trig = 6'b111110;
      m_gen = 32'h6A09E667; m_start = 1'b0;
    end else begin
      m_start = 1'b0;
      if (m_st == 0) begin
        lo = -1;
        for (int b = 4; b >= 1; b--) if (m_trig[b]) lo = b;
        if (m_trig[5]) begin m_st = 1; tlog.push_back(5); end
        else if (lo > 0) begin m_st = 2; m_bank = lo - 1; m_idx = 0; tlog.push_back(lo); end
        else if (m_trig[0]) begin m_start = 1'b1; dn[0] = 1'b1; tlog.push_back(0); end
      end else if (m_st == 1) begin
        if (ent_ack && ent_data != 0) begin m_gen = ent_data; dn[5] = 1'b1; m_st = 0; end
      end else begin
        if (wr_ready) begin
          m_gen = gen_step(m_gen);
          wcount[m_bank]++;
          if (m_idx == blen(m_bank) - 1) begin dn[m_bank + 1] = 1'b1; m_st = 0; end
          else m_idx++;
        end
      end
      m_trig = (m_trig & ~dn) | (trig_we ? trig_wdata : 6'b0);
    end
  end

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h cycle=%0d", r, act, exp, cyc);
    end
  endtask

  task automatic compare();
    chk("R2 trig_q", 64'(trig_q), 64'(m_trig));
    chk("R7 idle", 64'(idle), 64'(m_trig[5:1] == 0));
    chk("R4 ent_req", 64'(ent_req), 64'(m_st == 1));
    chk("R3 wr_valid", 64'(wr_valid), 64'(m_st == 2));
    chk("R8 start_pulse", 64'(start_pulse), 64'(m_start));
    if (m_st == 2) begin
      chk("R5 wr_bank", 64'(wr_bank), 64'(m_bank));
      chk("R5 wr_idx", 64'(wr_idx), 64'(m_idx));
      chk("R6 wr_data", 64'(wr_data), 64'(m_gen));
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cyc++;
    if (cyc > LIMIT) begin
      bad++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    compare();
    if (ent_ack) ent_ack = 1'b0;
    else if (ent_req) begin
      if (ent_cnt == 0) begin
        ent_ack = 1'b1;
        ent_data = zero_next ? 32'h0 : seed_src;
        zero_next = 0;
        seed_src = seed_src * 32'd69069 + 32'd1;
        ent_cnt = 2;
      end else ent_cnt--;
    end
    wr_ready = (ready_mode == 1) ? 1'b1 : (ready_mode == 2) ? 1'b0 : ((cyc % 3) != 1);
  endtask

  task automatic write_trig(logic [5:0] v);
    trig_we = 1'b1; trig_wdata = v;
    tick();
    trig_we = 1'b0; trig_wdata = '0;
  endtask

  task automatic wait_idle();
    while (!(m_st == 0 && m_trig == 0)) tick();
    tick();
  endtask

  task automatic chk_log(string r, int exp[$]);
    chk({r, " task count"}, 64'(tlog.size()), 64'(exp.size()));
    for (int i = 0; i < exp.size() && i < tlog.size(); i++)
      chk({r, " task order"}, 64'(tlog[i]), 64'(exp[i]));
    tlog.delete();
  endtask

  initial begin
    for (int b = 0; b < 4; b++) wcount[b] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 and R9: reset value of the trigger bits
    chk("R1 reset trig_q", 64'(trig_q), 64'h3E);
    chk("R9 reset idle low", 64'(idle), 64'h0);
    zero_next = 1;  // R4: first seed offered is zero
    wait_idle();
    chk_log("R9", '{5, 1, 2, 3, 4});
    chk("R5 key words", 64'(wcount[0]), 64'(KW));
    chk("R5 iv words", 64'(wcount[1]), 64'(IW));
    chk("R5 din words", 64'(wcount[2]), 64'(DW));
    chk("R5 dout words", 64'(wcount[3]), 64'(DW));
    chk("R9 idle after wipe", 64'(idle), 64'h1);

    // R3/R8: IV wipe before start
    write_trig(6'b000101);
    wait_idle();
    chk_log("R3", '{2, 0});

    // R2: zero write changes nothing
    write_trig(6'b000000);
    repeat (4) tick();
    chk("R2 zero write trig_q", 64'(trig_q), 64'h0);
    chk_log("R2", '{});

    // R3: all bits at once
    write_trig(6'b111111);
    wait_idle();
    chk_log("R3", '{5, 1, 2, 3, 4, 0});

    // R2: re-set in the completion cycle of the key wipe
    ready_mode = 1;
    write_trig(6'b000010);
    while (!(wr_valid && wr_idx == XW'(KW - 1))) tick();
    write_trig(6'b000010);
    wait_idle();
    chk_log("R2", '{1, 1});

    // R5: back-pressure holds the word
    ready_mode = 2;
    write_trig(6'b010000);
    repeat (6) tick();
    chk("R5 stalled idx", 64'(wr_idx), 64'h0);
    chk("R5 stalled valid", 64'(wr_valid), 64'h1);
    ready_mode = 0;
    wait_idle();
    chk_log("R5", '{4});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule